// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block adds in-band software flow control to one serial channel. On the receive path it compares each incoming character with two programmable control codes, "stop" (Xoff) and "go" (Xon). A stop code halts the local transmitter once the character it is currently sending has finished. A go code lets the transmitter run again. While flow control is enabled, neither code is passed on to the receive FIFO. An optional mode lets any received character release a halted transmitter.

On the transmit path the block watches the receive FIFO fill level. When the level reaches a programmed high-water mark, it asks the transmitter to send a stop code ahead of any queued data. It asks only once. When the level later falls to a low-water mark, it asks for a go code, again only once. The request is held until the transmitter acknowledges it.

Top module: `swfc_top`

## Requirements
- R1: With flow control on, a received character that matches neither code is written to the FIFO on the cycle after its strobe, with its value unchanged.
- R2: With flow control on, a received character equal to the current Xon or Xoff code is never written to the FIFO.
- R3: An Xoff received while `tx_busy` is low raises `tx_halt` on the next cycle.
- R4: An Xoff received while `tx_busy` is high leaves `tx_halt` low until `tx_busy` goes low. `tx_halt` then rises on the following cycle.
- R5: An Xon clears `tx_halt` on the next cycle. It also cancels a halt that is still waiting for the current character to finish.
- R6: With `any_resume` set, any received character other than the Xoff code clears `tx_halt` on the next cycle. Such a character is still stored as data unless it is the Xon code.
- R7: With flow control off, `tx_halt` is low in the same cycle. Every received character, including either code, is stored, and an Xoff has no effect on `tx_halt`.
- R8: When `rx_fifo_lvl >= halt_lvl` and no stop code is outstanding, `ins_req` rises on the next cycle with `ins_char` equal to the Xoff code. It stays high with a stable `ins_char` until `ins_ack`. It is not raised again while the level stays high.
- R9: After a stop code has been requested, `rx_fifo_lvl <= resume_lvl` raises `ins_req` with `ins_char` equal to the Xon code on the next cycle. This happens once per crossing.
- R10: The Xon and Xoff codes come from `xon_code` and `xoff_code` at the time of use, so reprogramming them changes which characters are matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Software flow control enable |
| any_resume | input | 1 | Any received character releases the halt |
| xon_code | input | 8 | Go character |
| xoff_code | input | 8 | Stop character |
| halt_lvl | input | 7 | FIFO level at which Xoff is requested |
| resume_lvl | input | 7 | FIFO level at which Xon is requested |
| rx_vld | input | 1 | One-cycle strobe for a received character |
| rx_char | input | 8 | Received character |
| rx_fifo_lvl | input | 7 | Current receive FIFO fill level |
| tx_busy | input | 1 | Transmitter is sending a character |
| ins_ack | input | 1 | Transmitter has taken the inserted character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character written to the FIFO |
| tx_halt | output | 1 | Transmitter must not start a new character |
| ins_req | output | 1 | Request to send `ins_char` ahead of queued data |
| ins_char | output | 8 | Control character to insert |

## Verification
The assertions assume that the environment behaves as follows:
- `rx_vld` is a single-cycle pulse.
- `ins_ack` is driven only while `ins_req` is high.
- `resume_lvl` is below `halt_lvl`.
- The two codes differ.

The stimulus stays within these limits. Characters are driven one strobe at a time with idle cycles between them, and each acknowledge lasts exactly one cycle after the request is observed. The threshold and code values are changed only while the block is quiet, and they always keep the two levels and the two codes distinct.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int CHAR_W = 8;
  typedef enum logic [0:0] {
    SEL_XON  = 1'b0,
    SEL_XOFF = 1'b1
  } code_sel_e;
endpackage

// File: rtl/swfc_rx_match.sv
module swfc_rx_match #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_en,
  input  logic          rx_vld,
  input  logic [CW-1:0] rx_char,
  input  logic [CW-1:0] xon_code,
  input  logic [CW-1:0] xoff_code,
  output logic          hit_xon,
  output logic          hit_xoff,
  output logic          fifo_wr,
  output logic [CW-1:0] fifo_data
);
  logic wr_nxt;

  always_comb begin
    hit_xon  = rx_vld && sw_en && (rx_char == xon_code);
    hit_xoff = rx_vld && sw_en && (rx_char == xoff_code);
    wr_nxt   = rx_vld && !hit_xon && !hit_xoff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= wr_nxt;
      if (rx_vld) fifo_data <= rx_char;
    end
  end

  // R2
  code_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && sw_en && (rx_char == xon_code || rx_char == xoff_code)) |=> !fifo_wr);

  // R7
  pass_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !sw_en) |=> (fifo_wr && fifo_data == $past(rx_char)));
endmodule

// File: rtl/swfc_halt_ctl.sv
module swfc_halt_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_en,
  input  logic any_resume,
  input  logic rx_vld,
  input  logic hit_xon,
  input  logic hit_xoff,
  input  logic tx_busy,
  output logic tx_halt
);
  logic stop_pend, stop_pend_nxt;
  logic halted, halted_nxt;
  logic resume_evt;

  always_comb begin
    resume_evt    = hit_xon || (any_resume && rx_vld && sw_en && !hit_xoff);
    stop_pend_nxt = stop_pend;
    halted_nxt    = halted;
    if (!sw_en) begin
      stop_pend_nxt = 1'b0;
      halted_nxt    = 1'b0;
    end else if (hit_xoff) begin
      if (!tx_busy) begin
        halted_nxt    = 1'b1;
        stop_pend_nxt = 1'b0;
      end else begin
        stop_pend_nxt = 1'b1;
      end
    end else if (resume_evt) begin
      stop_pend_nxt = 1'b0;
      halted_nxt    = 1'b0;
    end else if (stop_pend && !tx_busy) begin
      stop_pend_nxt = 1'b0;
      halted_nxt    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_pend <= 1'b0;
      halted    <= 1'b0;
    end else begin
      stop_pend <= stop_pend_nxt;
      halted    <= halted_nxt;
    end
  end

  assign tx_halt = halted && sw_en;

  // R3
  xoff_idle_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_xoff && !tx_busy) |=> halted);

  // R4
  halt_after_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(!tx_busy));

  // R5
  xon_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_xon |=> !halted);
endmodule

// File: rtl/swfc_ins_ctl.sv
module swfc_ins_ctl
  import swfc_pkg::*;
#(
  parameter int CW   = 8,
  parameter int LVLW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_en,
  input  logic [LVLW-1:0] rx_fifo_lvl,
  input  logic [LVLW-1:0] halt_lvl,
  input  logic [LVLW-1:0] resume_lvl,
  input  logic [CW-1:0]   xon_code,
  input  logic [CW-1:0]   xoff_code,
  input  logic            ins_ack,
  output logic            ins_req,
  output logic [CW-1:0]   ins_char
);
  logic      off_sent, off_sent_nxt;
  logic      req_nxt;
  code_sel_e sel, sel_nxt;

  always_comb begin
    off_sent_nxt = off_sent;
    req_nxt      = ins_req;
    sel_nxt      = sel;
    if (!sw_en) begin
      off_sent_nxt = 1'b0;
      req_nxt      = 1'b0;
    end else if (ins_req) begin
      if (ins_ack) req_nxt = 1'b0;
    end else if (!off_sent && rx_fifo_lvl >= halt_lvl) begin
      req_nxt      = 1'b1;
      sel_nxt      = SEL_XOFF;
      off_sent_nxt = 1'b1;
    end else if (off_sent && rx_fifo_lvl <= resume_lvl) begin
      req_nxt      = 1'b1;
      sel_nxt      = SEL_XON;
      off_sent_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_sent <= 1'b0;
      ins_req  <= 1'b0;
      sel      <= SEL_XON;
    end else begin
      off_sent <= off_sent_nxt;
      ins_req  <= req_nxt;
      sel      <= sel_nxt;
    end
  end

  assign ins_char = (sel == SEL_XOFF) ? xoff_code : xon_code;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack && sw_en) |=> (ins_req && $stable(sel)));

  // R8
  req_drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> !ins_req);
endmodule

// File: rtl/swfc_top.sv
module swfc_top #(
  parameter int CW   = swfc_pkg::CHAR_W,
  parameter int LVLW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_en,
  input  logic            any_resume,
  input  logic [CW-1:0]   xon_code,
  input  logic [CW-1:0]   xoff_code,
  input  logic [LVLW-1:0] halt_lvl,
  input  logic [LVLW-1:0] resume_lvl,
  input  logic            rx_vld,
  input  logic [CW-1:0]   rx_char,
  input  logic [LVLW-1:0] rx_fifo_lvl,
  input  logic            tx_busy,
  input  logic            ins_ack,
  output logic            fifo_wr,
  output logic [CW-1:0]   fifo_data,
  output logic            tx_halt,
  output logic            ins_req,
  output logic [CW-1:0]   ins_char
);
  logic hit_xon, hit_xoff;

  swfc_rx_match #(.CW(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .rx_vld(rx_vld), .rx_char(rx_char),
    .xon_code(xon_code), .xoff_code(xoff_code), .hit_xon(hit_xon),
    .hit_xoff(hit_xoff), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  swfc_halt_ctl u_halt (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .any_resume(any_resume),
    .rx_vld(rx_vld), .hit_xon(hit_xon), .hit_xoff(hit_xoff),
    .tx_busy(tx_busy), .tx_halt(tx_halt)
  );

  swfc_ins_ctl #(.CW(CW), .LVLW(LVLW)) u_ins (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .rx_fifo_lvl(rx_fifo_lvl),
    .halt_lvl(halt_lvl), .resume_lvl(resume_lvl), .xon_code(xon_code),
    .xoff_code(xoff_code), .ins_ack(ins_ack), .ins_req(ins_req),
    .ins_char(ins_char)
  );

  // R6
  any_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && any_resume && rx_vld && rx_char != xoff_code && $past(sw_en)) |=> !tx_halt);
endmodule

// File: tb/swfc_top_tb_top.sv
module swfc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_en = 1'b0, any_resume = 1'b0;
  logic [7:0] xon_code = 8'h11, xoff_code = 8'h13;
  logic [6:0] halt_lvl = 7'd48, resume_lvl = 7'd16;
  logic       rx_vld = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [6:0] rx_fifo_lvl = 7'd0;
  logic       tx_busy = 1'b0, ins_ack = 1'b0;
  logic       fifo_wr, tx_halt, ins_req;
  logic [7:0] fifo_data, ins_char;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  swfc_top dut_i (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .any_resume(any_resume),
    .xon_code(xon_code), .xoff_code(xoff_code), .halt_lvl(halt_lvl),
    .resume_lvl(resume_lvl), .rx_vld(rx_vld), .rx_char(rx_char),
    .rx_fifo_lvl(rx_fifo_lvl), .tx_busy(tx_busy), .ins_ack(ins_ack),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .tx_halt(tx_halt),
    .ins_req(ins_req), .ins_char(ins_char)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare every FIFO write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      if (exp_q.size() == 0) check("R2 unexpected write", {24'd0, fifo_data}, 32'hFFFF_FFFF);
      else check("R1 fifo data", {24'd0, fifo_data}, {24'd0, exp_q.pop_front()});
    end
  end

  // driver: one-cycle strobe, expected item pushed when the character is stored
  task automatic send(input logic [7:0] ch, input bit stored);
    if (stored) exp_q.push_back(ch);
    rx_vld = 1'b1; rx_char = ch;
    @(negedge clk);
    rx_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset tx_halt", tx_halt, 0);
    check("reset ins_req", ins_req, 0);
    check("reset fifo_wr", fifo_wr, 0);
    rst_n = 1'b1;
    sw_en = 1'b1;
    @(negedge clk);

    // R1 plain data
    send(8'h41, 1); send(8'h00, 1); send(8'hFF, 1);
    // R3 and R2: Xoff with idle transmitter
    send(8'h13, 0);
    check("R3 halt after xoff", tx_halt, 1);
    // R5 and R2: Xon
    send(8'h11, 0);
    check("R5 xon release", tx_halt, 0);
    // R4: deferred halt
    tx_busy = 1'b1;
    send(8'h13, 0);
    check("R4 no halt while busy", tx_halt, 0);
    @(negedge clk);
    check("R4 still no halt", tx_halt, 0);
    tx_busy = 1'b0;
    @(negedge clk);
    check("R4 halt after char", tx_halt, 1);
    send(8'h11, 0);
    // R5: Xon cancels a pending halt
    tx_busy = 1'b1;
    send(8'h13, 0);
    send(8'h11, 0);
    tx_busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 pending cancelled", tx_halt, 0);
    // R6: resume on any character
    any_resume = 1'b1;
    send(8'h13, 0);
    check("R6 halted", tx_halt, 1);
    send(8'h13, 0);
    check("R6 xoff keeps halt", tx_halt, 1);
    send(8'h5A, 1);
    check("R6 data releases", tx_halt, 0);
    send(8'h13, 0);
    send(8'h11, 0);
    check("R6 xon releases", tx_halt, 0);
    any_resume = 1'b0;
    // R7: disable while halted
    send(8'h13, 0);
    check("R7 halted before off", tx_halt, 1);
    sw_en = 1'b0;
    #1;
    check("R7 halt cleared same cycle", tx_halt, 0);
    @(negedge clk);
    send(8'h13, 1);
    send(8'h11, 1);
    check("R7 xoff ignored when off", tx_halt, 0);
    sw_en = 1'b1;
    @(negedge clk);
    check("R7 no halt after re-enable", tx_halt, 0);
    // R10: reprogram Xoff
    xoff_code = 8'h0F;
    send(8'h13, 1);
    check("R10 old code is data", tx_halt, 0);
    send(8'h0F, 0);
    check("R10 new code halts", tx_halt, 1);
    send(8'h11, 0);
    // R8: high-water mark
    rx_fifo_lvl = 7'd48;
    @(negedge clk);
    check("R8 xoff request", ins_req, 1);
    check("R8 xoff char", ins_char, 8'h0F);
    @(negedge clk);
    check("R8 held", ins_req, 1);
    ins_ack = 1'b1;
    @(negedge clk);
    ins_ack = 1'b0;
    check("R8 dropped after ack", ins_req, 0);
    rx_fifo_lvl = 7'd60;
    repeat (3) @(negedge clk);
    check("R8 sent once", ins_req, 0);
    rx_fifo_lvl = 7'd30;
    repeat (2) @(negedge clk);
    check("R9 no xon above low mark", ins_req, 0);
    // R9: low-water mark
    rx_fifo_lvl = 7'd16;
    @(negedge clk);
    check("R9 xon request", ins_req, 1);
    check("R9 xon char", ins_char, 8'h11);
    ins_ack = 1'b1;
    @(negedge clk);
    ins_ack = 1'b0;
    rx_fifo_lvl = 7'd2;
    repeat (3) @(negedge clk);
    check("R9 sent once", ins_req, 0);
    // R8 again, then disable drops the request
    rx_fifo_lvl = 7'd50;
    @(negedge clk);
    check("R8 second crossing", ins_req, 1);
    sw_en = 1'b0;
    @(negedge clk);
    check("R8 off drops request", ins_req, 0);

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule